// File: doc/BRIEF.md
# Auto-Reload Up-Counting Timer

This block is a general-purpose up-counter paced by a programmable prescaler. The counter runs from zero up to an active reload limit, then wraps to zero and raises an update event. A single-cycle register write port programs the block. The reload limit and the prescaler divisor each live in a pending/active register pair. The reload pair can work as a true double buffer: a new limit written during a period then waits for the next update event.

The count clock can come from four sources. The first is the internal clock. The second is a rising edge on an asynchronous pin. The third is a rising edge on an asynchronous trigger line. The fourth is a synchronous chain input, usually wired to another timer's update pulse, so that one timer can act as a prescaler for the next. Each update event sets a sticky flag. The interrupt output is asserted while that flag is set and interrupts are enabled.

Top module: `autoreload_timer`

## Requirements
- R1: After reset, `count`, `update_evt`, `update_flag` and `irq` are all 0.
- R2: With the internal source selected and enable set, `count` advances once every (P+1) clock cycles, where P is the active prescaler value. While enable is 0 and no software update is written, `count` holds.
- R3: With preload enabled, a reload write changes only the pending limit. The running period keeps its old length, and the new limit governs the period that follows the next update event.
- R4: A count tick that arrives while `count` is at or above the active limit sets `count` to 0 at that clock edge. In the same edge, `update_evt` is raised for exactly that one following cycle and `update_flag` is set.
- R5: With preload disabled, a reload write takes effect in the active limit at the same edge.
- R6: A prescaler write changes only the pending divisor. The divisor is copied to the active one at the next update event.
- R7: Writing 1 to bit 0 at address 1 clears `count` and the prescaler counter and copies both pending values to the active ones. It raises `update_evt` for one cycle and sets the flag. No stored request bit remains afterwards.
- R8: `update_flag` stays set until a write to address 4 with bit 0 = 0 clears it. Writing 1 there has no effect. An update in the same cycle as a clear wins.
- R9: `irq` is 1 exactly when `update_flag` and the interrupt-enable bit are both 1.
- R10: For the pin source (select 1) and the trigger source (select 2), the input passes through two synchronizer flops followed by a rising-edge detector. A rising edge applied before clock edge k is counted at edge k+2, and a level that stays high adds no further counts.
- R11: For the chain source (select 3), every clock cycle with `chain_in` high is one count tick.
- R12: Register map. Address 0 is control: bit 0 enable, bit 1 preload enable, bit 2 interrupt enable, bits 4:3 source (0 internal, 1 pin, 2 trigger, 3 chain). Address 1 bit 0 is the update command. Address 2 is the prescaler value. Address 3 is the reload limit. Address 4 bit 0 holds or clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| pin_in | input | 1 | Asynchronous external pin, counted on rising edges |
| trig_in | input | 1 | Asynchronous external trigger, counted on rising edges |
| chain_in | input | 1 | Synchronous tick from another timer |
| count | output | W | Current counter value |
| update_evt | output | 1 | One-cycle update event pulse |
| update_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked every cycle. They cover the following:
- the counter is zero whenever an update pulse is present;
- the flag accompanies every pulse;
- a software update produces a pulse and a cleared counter on the next cycle;
- the active limit stays frozen while preload is on and no update occurs;
- the counter holds while disabled;
- a flag clear takes effect;
- the interrupt never fires without the flag.

Other behaviours need whole scenarios run by the bench:
- the length of a period that straddles a mid-period reload write;
- the deferred effect of a prescaler change;
- the exact two-cycle synchronizer latency;
- edge-only counting of a held pin.

// File: rtl/autoreload_timer.sv
module autoreload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         pin_in,
  input  logic         trig_in,
  input  logic         chain_in,
  output logic [W-1:0] count,
  output logic         update_evt,
  output logic         update_flag,
  output logic         irq
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_PSC  = 3'd2;
  localparam logic [2:0] A_ARR  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  logic         en, pre_en, ie;
  logic [1:0]   src;
  logic [W-1:0] psc_pre, psc_act, psc_cnt;
  logic [W-1:0] arr_pre, arr_act;
  logic [2:0]   pin_s, trg_s;
  logic         tick, psc_wrap, wrap, upd;

  wire wr_ctrl = wr_en && wr_addr == A_CTRL;
  wire sw_upd  = wr_en && wr_addr == A_CMD && wr_data[0];
  wire wr_psc  = wr_en && wr_addr == A_PSC;
  wire wr_arr  = wr_en && wr_addr == A_ARR;
  wire wr_clr  = wr_en && wr_addr == A_STAT && !wr_data[0];

  wire pin_edge = pin_s[1] & ~pin_s[2];
  wire trg_edge = trg_s[1] & ~trg_s[2];

  always_comb begin
    case (src)
      2'd0:    tick = en;
      2'd1:    tick = en & pin_edge;
      2'd2:    tick = en & trg_edge;
      default: tick = en & chain_in;
    endcase
  end

  assign psc_wrap = tick && psc_cnt == psc_act;
  assign wrap     = psc_wrap && count >= arr_act;
  assign upd      = wrap || sw_upd;
  assign irq      = update_flag & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s <= '0;
      trg_s <= '0;
    end else begin
      pin_s <= {pin_s[1:0], pin_in};
      trg_s <= {trg_s[1:0], trig_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pre_en <= 1'b0;
      ie     <= 1'b0;
      src    <= 2'd0;
    end else if (wr_ctrl) begin
      en     <= wr_data[0];
      pre_en <= wr_data[1];
      ie     <= wr_data[2];
      src    <= wr_data[4:3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      psc_cnt <= '0;
    end else if (sw_upd) begin
      count   <= '0;
      psc_cnt <= '0;
    end else begin
      if (tick)     psc_cnt <= psc_wrap ? '0 : psc_cnt + 1'b1;
      if (psc_wrap) count   <= wrap ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_pre <= '0;
      psc_act <= '0;
      arr_pre <= '0;
      arr_act <= '0;
    end else begin
      if (wr_psc) psc_pre <= wr_data;
      if (upd)    psc_act <= psc_pre;
      if (wr_arr) arr_pre <= wr_data;
      if (wr_arr && !pre_en) arr_act <= wr_data;
      else if (upd)          arr_act <= arr_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      update_evt  <= 1'b0;
      update_flag <= 1'b0;
    end else begin
      update_evt <= upd;
      if (upd)         update_flag <= 1'b1;
      else if (wr_clr) update_flag <= 1'b0;
    end
  end

  assert_evt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |-> count == '0);
  assert_evt_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |-> update_flag);
  assert_sw_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (update_evt && count == '0));
  assert_preload_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !upd) |=> $stable(arr_act));
  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sw_upd) |=> $stable(count));
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !upd) |=> !update_flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> update_flag);

endmodule

// File: tb/tb_autoreload_timer.sv
module tb_autoreload_timer;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pin_in = 1'b0, trig_in = 1'b0, chain_in = 1'b0;
  logic [W-1:0] count;
  logic update_evt, update_flag, irq;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autoreload_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_in(pin_in), .trig_in(trig_in), .chain_in(chain_in),
    .count(count), .update_evt(update_evt), .update_flag(update_flag), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic m_en, m_pre, m_ie, m_evt, m_flag;
  logic [1:0] m_src;
  logic [W-1:0] m_cnt, m_pc, m_psc_pre, m_psc_act, m_arr_pre, m_arr_act;
  logic [2:0] m_pin, m_trg;

  always @(posedge clk) begin : model
    logic tk, pw, cw, sw, up;
    if (!rst_n) begin
      m_en = 0; m_pre = 0; m_ie = 0; m_src = 0; m_evt = 0; m_flag = 0;
      m_cnt = 0; m_pc = 0; m_psc_pre = 0; m_psc_act = 0; m_arr_pre = 0; m_arr_act = 0;
      m_pin = 0; m_trg = 0;
    end else begin
      case (m_src)
        2'd0: tk = m_en;
        2'd1: tk = m_en && m_pin[1] && !m_pin[2];
        2'd2: tk = m_en && m_trg[1] && !m_trg[2];
        default: tk = m_en && chain_in;
      endcase
      pw = tk && m_pc == m_psc_act;
      cw = pw && m_cnt >= m_arr_act;
      sw = wr_en && wr_addr == 3'd1 && wr_data[0];
      up = cw || sw;
      if (sw) begin m_cnt = 0; m_pc = 0; end
      else begin
        if (tk) m_pc = pw ? '0 : m_pc + 1'b1;
        if (pw) m_cnt = cw ? '0 : m_cnt + 1'b1;
      end
      m_evt = up;
      if (up) m_flag = 1;
      else if (wr_en && wr_addr == 3'd4 && !wr_data[0]) m_flag = 0;
      if (up) begin m_arr_act = m_arr_pre; m_psc_act = m_psc_pre; end
      if (wr_en && wr_addr == 3'd3) begin
        m_arr_pre = wr_data;
        if (!m_pre) m_arr_act = wr_data;
      end
      if (wr_en && wr_addr == 3'd2) m_psc_pre = wr_data;
      if (wr_en && wr_addr == 3'd0) begin
        m_en = wr_data[0]; m_pre = wr_data[1]; m_ie = wr_data[2]; m_src = wr_data[4:3];
      end
      m_pin = {m_pin[1:0], pin_in};
      m_trg = {m_trg[1:0], trig_in};
    end
  end

  always @(negedge clk) if (rst_n && chk_on) begin
    chk(count == m_cnt, "R2 count", count, m_cnt);
    chk(update_evt == m_evt, "R4 update_evt", update_evt, m_evt);
    chk(update_flag == m_flag, "R8 update_flag", update_flag, m_flag);
    chk(irq == (m_flag & m_ie), "R9 irq", irq, m_flag & m_ie);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_evt();
    while (!update_evt) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!update_evt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0 && !update_evt && !update_flag && !irq, "R1 reset state",
        {count, update_evt, update_flag, irq}, 0);
    chk_on = 1'b1;

    // R12 control: preload on, internal source
    wr(3'd0, 16'h0002); wr(3'd2, 0); wr(3'd3, 9); wr(3'd1, 1); wr(3'd4, 0);
    wr(3'd0, 16'h0003);
    wait_evt();
    chk(count == 0, "R4 count zero at update", count, 0);
    // R3 mid-period write with preload on
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    wr(3'd3, 4); n++;
    while (!update_evt) begin @(negedge clk); n++; end
    chk(n == 10, "R3 current period unchanged", n, 10);
    measure(n);
    chk(n == 5, "R3 new limit on next period", n, 5);

    // R5 preload off: immediate
    wr(3'd0, 16'h0001);
    wr(3'd3, 20);
    n = 2;
    while (!update_evt) begin @(negedge clk); n++; end
    chk(n == 21, "R5 immediate reload", n, 21);

    // R6 prescaler deferred
    wr(3'd3, 4); wr(3'd2, 1);
    n = 2;
    while (!update_evt) begin @(negedge clk); n++; end
    chk(n == 5, "R6 prescaler not yet active", n, 5);
    measure(n);
    chk(n == 10, "R6 R2 divide by two after update", n, 10);

    // R7 software update
    @(negedge clk);
    wr(3'd1, 1);
    chk(update_evt && count == 0, "R7 update on command", {update_evt, count}, 32'h10000);
    @(negedge clk);
    chk(!update_evt && count == 0, "R7 single pulse", {update_evt, count}, 0);

    // R8 sticky flag
    chk(update_flag, "R8 flag set", update_flag, 1);
    wr(3'd4, 1);
    chk(update_flag, "R8 writing one keeps flag", update_flag, 1);
    wr(3'd4, 0);
    chk(!update_flag, "R8 clear", update_flag, 0);

    // R9 interrupt
    wr(3'd0, 16'h0005);
    wait_evt();
    chk(irq, "R9 irq with flag and enable", irq, 1);
    wr(3'd4, 0);
    chk(!irq, "R9 irq drops with flag", irq, 0);

    // R2 disabled hold
    wr(3'd0, 16'h0000);
    c = count;
    repeat (6) @(negedge clk);
    chk(count == c, "R2 hold while disabled", count, c);

    // R10 pin source latency and edge-only counting
    wr(3'd0, 16'h0009); wr(3'd2, 0); wr(3'd3, 50); wr(3'd1, 1);
    pin_in = 1'b1;
    @(negedge clk);
    chk(count == 0, "R10 after one edge", count, 0);
    @(negedge clk);
    chk(count == 0, "R10 after two edges", count, 0);
    @(negedge clk);
    chk(count == 1, "R10 counted at third edge", count, 1);
    repeat (10) @(negedge clk);
    chk(count == 1, "R10 held level no extra count", count, 1);
    pin_in = 1'b0;
    repeat (4) @(negedge clk);

    // R11 chain source
    wr(3'd0, 16'h0019); wr(3'd1, 1);
    chain_in = 1'b1;
    repeat (3) @(negedge clk);
    chain_in = 1'b0;
    chk(count == 3, "R11 chain ticks", count, 3);
    @(negedge clk);
    chk(count == 3, "R11 no tick when low", count, 3);

    // constrained random against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 5000; i++) begin
      logic [2:0] a;
      logic [W-1:0] d;
      wr_en = 1'b0;
      if ($urandom % 100 < 12) begin
        a = 3'($urandom % 5);
        case (a)
          3'd0: d = W'(($urandom % 32) | (($urandom % 10) < 8 ? 1 : 0));
          3'd1: d = W'($urandom % 2);
          3'd2: d = W'($urandom % 4);
          3'd3: d = W'($urandom % 24);
          default: d = W'($urandom % 2);
        endcase
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end
      if ($urandom % 100 < 30) pin_in = ~pin_in;
      if ($urandom % 100 < 30) trig_in = ~trig_in;
      chain_in = ($urandom % 4) == 0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule